// File: doc/BRIEF.md
# BF16 Pairwise Dot-Product Accumulator

This unit takes two 64-bit source words, each holding four bfloat16 values, and a 64-bit accumulator word holding two single-precision values. Each 32-bit output lane multiplies two adjacent bfloat16 pairs, adds the two products together, and then adds that sum into the matching single-precision accumulator lane. Two arithmetic stages sit between the input handshake and the result.

A narrow operation is one beat. A wide operation is two consecutive beats that cover an even/odd register pair, and the caller supplies the three register indices with it. A wide operation whose first beat names an odd register index is refused. Instead of a result, the unit raises a one-cycle illegal pulse. Arithmetic always runs under one fixed setting: round-to-nearest-even, subnormals flushed to signed zero, and a single canonical quiet NaN. The unit has no rounding controls and reports no exception status.

Top module: `bf16_pair_dot`

## Requirements
- R1: Bit k of the element numbering places BF16 element k of a source word at bits [16k+15:16k]. Output lane e, at bits [32e+31:32e], equals accumulator lane e plus (A[2e]*B[2e] + A[2e+1]*B[2e+1]).
- R2: The two products of a lane are added to each other first, with rounding, and only that sum is added to the accumulator. So 2^30 + (-2^30) followed by adding 1.0 yields exactly 1.0.
- R3: Every addition rounds to nearest with ties to even, and that includes shifted-out bits and renormalisation after subtraction.
- R4: Subnormal inputs (exponent field 0) are read as signed zero, and any result below the smallest normal is returned as signed zero.
- R5: Infinity times zero, the sum of opposite infinities, and any NaN operand all give 32'h7FC00000. No other NaN encoding ever appears on a valid output lane.
- R6: A product or sum too large for single precision becomes an infinity carrying the result's sign.
- R7: With wide_mode=0, a beat accepted on a clock edge (in_valid and in_ready high) raises out_valid for exactly one cycle after the second following edge. Register indices have no effect, and one beat may be accepted every cycle.
- R8: With wide_mode=1, two accepted beats form one operation. Each beat is processed by the R1 rule, and the two results come out in order on consecutive valid cycles.
- R9: The first beat of a wide operation is illegal when bit 0 of any of the three indices is 1. In that case out_illegal pulses for one cycle at the R7 latency, out_valid stays low, and the next wide beat is again treated as a first beat.
- R10: The indices of the second beat of a wide operation are not checked.
- R11: While rst is high, in_ready is low. After reset, out_valid and out_illegal are low.
- R12: When both addends are zero, the sum is -0 only if both addends are -0. An exact cancellation of nonzero values gives +0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat can be taken (low in reset) |
| wide_mode | input | 1 | 0: one-beat operation, 1: two-beat operation |
| dst_idx | input | 5 | Destination register index |
| srca_idx | input | 5 | First source register index |
| srcb_idx | input | 5 | Second source register index |
| srca_word | input | 64 | Four BF16 elements of source A |
| srcb_word | input | 64 | Four BF16 elements of source B |
| acc_word | input | 64 | Two FP32 accumulator lanes |
| out_valid | output | 1 | out_word holds a result this cycle |
| out_illegal | output | 1 | The beat accepted two cycles ago was refused |
| out_word | output | 64 | Two FP32 result lanes |

## Verification
If the even/odd beat tracker goes wrong, it shows within one operation. A refused first beat would let a later odd-indexed beat through as a valid result, or a legal pair would raise an illegal pulse. Both are visible two cycles after the beat. Faults in the arithmetic stages (lost sticky bits, wrong normalisation shift, wrong order of the additions, missing flush) show up in out_word on the very beat that exercises them. The vectors are therefore chosen to sit on ties, cancellations, overflow and underflow, where a single wrong bit changes the result word.

// File: rtl/bf16dot_pkg.sv
package bf16dot_pkg;

    typedef struct packed {
        logic        sign;
        logic [7:0]  exp;
        logic [22:0] frac;
    } fp32_t;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } beat_phase_e;

    localparam fp32_t QNAN = 32'h7FC00000;

    // Exact BF16 x BF16 product in FP32 under the fixed mode.
    function automatic fp32_t bf16_mul(logic [15:0] a, logic [15:0] b);
        fp32_t             r;
        logic              s, anan, bnan, ainf, binf, az, bz;
        logic [15:0]       ma, mb, p;
        logic signed [9:0] e;
        r    = '0;
        s    = a[15] ^ b[15];
        anan = (a[14:7] == 8'hFF) && (a[6:0] != 7'd0);
        bnan = (b[14:7] == 8'hFF) && (b[6:0] != 7'd0);
        ainf = (a[14:7] == 8'hFF) && (a[6:0] == 7'd0);
        binf = (b[14:7] == 8'hFF) && (b[6:0] == 7'd0);
        az   = (a[14:7] == 8'h00);
        bz   = (b[14:7] == 8'h00);
        ma   = {8'd0, 1'b1, a[6:0]};
        mb   = {8'd0, 1'b1, b[6:0]};
        p    = ma * mb;
        e    = 10'(a[14:7]) + 10'(b[14:7]) - 10'd127;
        if (anan || bnan || (ainf && bz) || (binf && az)) begin
            r = QNAN;
        end else if (ainf || binf) begin
            r = {s, 8'hFF, 23'd0};
        end else if (az || bz) begin
            r = {s, 31'd0};
        end else begin
            if (p[15]) begin
                e = e + 10'sd1;
                r = {s, e[7:0], p[14:0], 8'd0};
            end else begin
                r = {s, e[7:0], p[13:0], 9'd0};
            end
            if (e >= 10'sd255)    r = {s, 8'hFF, 23'd0};
            else if (e <= 10'sd0) r = {s, 31'd0};
        end
        return r;
    endfunction

    // FP32 addition: round-to-nearest-even, flush-to-zero, default NaN.
    function automatic fp32_t fp32_add(fp32_t x, fp32_t y);
        fp32_t             r, big, lit;
        logic              xnan, ynan, xinf, yinf, xz, yz, sticky;
        logic [7:0]        d;
        logic [26:0]       xs, ext, ys, diff, nm;
        logic [27:0]       sum;
        logic [24:0]       rm;
        logic signed [9:0] e;
        int                lz;
        r = '0; big = x; lit = y; sticky = 1'b0; ys = '0; nm = '0;
        sum = '0; diff = '0; lz = 0;
        xnan = (x.exp == 8'hFF) && (x.frac != 23'd0);
        ynan = (y.exp == 8'hFF) && (y.frac != 23'd0);
        xinf = (x.exp == 8'hFF) && (x.frac == 23'd0);
        yinf = (y.exp == 8'hFF) && (y.frac == 23'd0);
        xz   = (x.exp == 8'h00);
        yz   = (y.exp == 8'h00);
        if (xnan || ynan || (xinf && yinf && (x.sign != y.sign))) begin
            r = QNAN;
        end else if (xinf) begin
            r = x;
        end else if (yinf) begin
            r = y;
        end else if (xz && yz) begin
            r = {x.sign & y.sign, 31'd0};
        end else if (xz) begin
            r = y;
        end else if (yz) begin
            r = x;
        end else begin
            if ({x.exp, x.frac} < {y.exp, y.frac}) begin
                big = y; lit = x;
            end
            d   = big.exp - lit.exp;
            xs  = {1'b1, big.frac, 3'd0};
            ext = {1'b1, lit.frac, 3'd0};
            if (d > 8'd26) begin
                ys = 27'd1;
            end else begin
                ys     = ext >> d;
                sticky = |(ext & ((27'd1 << d) - 27'd1));
                ys[0]  = ys[0] | sticky;
            end
            e = 10'(big.exp);
            if (big.sign == lit.sign) begin
                sum = {1'b0, xs} + {1'b0, ys};
                if (sum[27]) begin
                    nm    = sum[27:1];
                    nm[0] = nm[0] | sum[0];
                    e     = e + 10'sd1;
                end else begin
                    nm = sum[26:0];
                end
            end else begin
                diff = xs - ys;
                lz   = 27;
                for (int i = 0; i < 27; i++) if (diff[i]) lz = 26 - i;
                nm = diff << lz;
                e  = e - 10'(lz);
            end
            if (nm == 27'd0) begin
                r = '0;
            end else begin
                rm = {1'b0, nm[26:3]};
                if (nm[2] && (nm[1] || nm[0] || nm[3])) rm = rm + 25'd1;
                if (rm[24]) begin
                    rm = rm >> 1;
                    e  = e + 10'sd1;
                end
                if (e >= 10'sd255)    r = {big.sign, 8'hFF, 23'd0};
                else if (e <= 10'sd0) r = {big.sign, 31'd0};
                else                  r = {big.sign, e[7:0], rm[22:0]};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/bf16dot_ctrl.sv
module bf16dot_ctrl
    import bf16dot_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             wide_mode,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] srca_idx,
    input  logic [IDX_W-1:0] srcb_idx,
    output logic             in_ready,
    output logic             load_s1,
    output logic             load_s2,
    output logic             out_valid,
    output logic             out_illegal,
    output logic             beat_odd
);
    beat_phase_e phase_q;
    logic        accept, odd_index, refuse;
    logic        s1_valid_q, s1_illegal_q;
    logic        idx_hi_unused;

    assign in_ready      = !rst;
    assign accept        = in_valid && in_ready;
    assign odd_index     = dst_idx[0] | srca_idx[0] | srcb_idx[0];
    assign refuse        = wide_mode && (phase_q == PH_FIRST) && odd_index;
    assign load_s1       = accept && !refuse;
    assign load_s2       = s1_valid_q;
    assign beat_odd      = (phase_q == PH_SECOND);
    assign idx_hi_unused = ^{dst_idx[IDX_W-1:1], srca_idx[IDX_W-1:1], srcb_idx[IDX_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_FIRST;
            s1_valid_q   <= 1'b0;
            s1_illegal_q <= 1'b0;
            out_valid    <= 1'b0;
            out_illegal  <= 1'b0;
        end else begin
            s1_valid_q   <= accept && !refuse;
            s1_illegal_q <= accept && refuse;
            out_valid    <= s1_valid_q;
            out_illegal  <= s1_illegal_q;
            if (accept) begin
                phase_q <= (wide_mode && phase_q == PH_FIRST && !refuse) ? PH_SECOND : PH_FIRST;
            end
        end
    end
endmodule

// File: rtl/bf16dot_lane.sv
module bf16dot_lane
    import bf16dot_pkg::*;
#(
    parameter int ELEM_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic                clk,
    input  logic                load_s1,
    input  logic                load_s2,
    input  logic [2*ELEM_W-1:0] a_pair,
    input  logic [2*ELEM_W-1:0] b_pair,
    input  logic [ACC_W-1:0]    acc_lane,
    output logic [ACC_W-1:0]    res_lane
);
    fp32_t prod_lo, prod_hi, pair_sum;
    fp32_t pair_sum_q, acc_q, res_q;

    assign prod_lo  = bf16_mul(a_pair[ELEM_W-1:0],        b_pair[ELEM_W-1:0]);
    assign prod_hi  = bf16_mul(a_pair[2*ELEM_W-1:ELEM_W], b_pair[2*ELEM_W-1:ELEM_W]);
    assign pair_sum = fp32_add(prod_lo, prod_hi);

    always_ff @(posedge clk) begin
        if (load_s1) begin
            pair_sum_q <= pair_sum;
            acc_q      <= acc_lane;
        end
        if (load_s2) begin
            res_q <= fp32_add(acc_q, pair_sum_q);
        end
    end

    assign res_lane = res_q;
endmodule

// File: rtl/bf16_pair_dot.sv
module bf16_pair_dot
    import bf16dot_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int ACC_W  = 32,
    parameter int ELEM_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              wide_mode,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [IDX_W-1:0]  srca_idx,
    input  logic [IDX_W-1:0]  srcb_idx,
    input  logic [WORD_W-1:0] srca_word,
    input  logic [WORD_W-1:0] srcb_word,
    input  logic [WORD_W-1:0] acc_word,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [WORD_W-1:0] out_word
);
    localparam int LANES  = WORD_W / ACC_W;
    localparam int PAIR_W = 2 * ELEM_W;

    logic load_s1, load_s2, beat_odd;

    bf16dot_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .wide_mode  (wide_mode),
        .dst_idx    (dst_idx),
        .srca_idx   (srca_idx),
        .srcb_idx   (srcb_idx),
        .in_ready   (in_ready),
        .load_s1    (load_s1),
        .load_s2    (load_s2),
        .out_valid  (out_valid),
        .out_illegal(out_illegal),
        .beat_odd   (beat_odd)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bf16dot_lane #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_lane (
            .clk     (clk),
            .load_s1 (load_s1),
            .load_s2 (load_s2),
            .a_pair  (srca_word[g*PAIR_W +: PAIR_W]),
            .b_pair  (srcb_word[g*PAIR_W +: PAIR_W]),
            .acc_lane(acc_word[g*ACC_W +: ACC_W]),
            .res_lane(out_word[g*ACC_W +: ACC_W])
        );
    end
endmodule

// File: rtl/bf16_pair_dot_checker.sv
module bf16_pair_dot_checker #(
    parameter int WORD_W = 64,
    parameter int ACC_W  = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              wide_mode,
    input logic [IDX_W-1:0]  dst_idx,
    input logic [IDX_W-1:0]  srca_idx,
    input logic [IDX_W-1:0]  srcb_idx,
    input logic              out_valid,
    input logic              out_illegal,
    input logic [WORD_W-1:0] out_word,
    input logic              beat_odd
);
    localparam int LANES = WORD_W / ACC_W;

    logic take;
    assign take = in_valid && in_ready;

    // R9: a refused beat never also yields a result
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_illegal));

    // R7: every accepted beat produces exactly one response two edges later
    a_r7_response: assert property (@(posedge clk) disable iff (rst)
        $past(take, 2) |-> (out_valid || out_illegal));

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (out_valid || out_illegal) |-> $past(take, 2));

    // R7: a narrow beat is never refused
    a_r7_narrow_ok: assert property (@(posedge clk) disable iff (rst)
        $past(take && !wide_mode, 2) |-> out_valid);

    // R9: odd index on a first wide beat is refused
    a_r9_refuse: assert property (@(posedge clk) disable iff (rst)
        $past(take && wide_mode && !beat_odd &&
              (dst_idx[0] || srca_idx[0] || srcb_idx[0]), 2) |-> out_illegal);

    // R5: only the canonical NaN leaves the unit
    for (genvar g = 0; g < LANES; g++) begin : g_nan
        a_r5_canon_nan: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_word[g*ACC_W+23 +: 8] == 8'hFF && out_word[g*ACC_W +: 23] != 23'd0)
            |-> out_word[g*ACC_W +: ACC_W] == 32'h7FC00000);
    end
endmodule

bind bf16_pair_dot bf16_pair_dot_checker #(
    .WORD_W(WORD_W), .ACC_W(ACC_W), .IDX_W(IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .wide_mode  (wide_mode),
    .dst_idx    (dst_idx),
    .srca_idx   (srca_idx),
    .srcb_idx   (srcb_idx),
    .out_valid  (out_valid),
    .out_illegal(out_illegal),
    .out_word   (out_word),
    .beat_odd   (beat_odd)
);

// File: tb/bf16_pair_dot_bench.sv
module bf16_pair_dot_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, wide_mode = 1'b0;
    logic [4:0]  dst_idx = '0, srca_idx = '0, srcb_idx = '0;
    logic [63:0] srca_word = '0, srcb_word = '0, acc_word = '0;
    logic        in_ready, out_valid, out_illegal;
    logic [63:0] out_word;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    bf16_pair_dot u_bf16_pair_dot (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .wide_mode(wide_mode), .dst_idx(dst_idx), .srca_idx(srca_idx),
        .srcb_idx(srcb_idx), .srca_word(srca_word), .srcb_word(srcb_word),
        .acc_word(acc_word), .out_valid(out_valid), .out_illegal(out_illegal),
        .out_word(out_word)
    );

    // {A, B, accumulator, expected}
    localparam logic [255:0] VEC [8] = '{
        {64'h3E80_C000_4040_3F80, 64'h4080_3FC0_3F00_4000, 64'h4120_0000_3F80_0000, 64'h4100_0000_4090_0000},
        {64'h3F80_3F80_4700_4700, 64'hBF80_3F80_C700_4700, 64'h8000_0000_3F80_0000, 64'h0000_0000_3F80_0000},
        {64'h0000_3F80_0000_3F80, 64'h0000_3380_0000_3380, 64'h3F80_0000_3F80_0001, 64'h3F80_0000_3F80_0002},
        {64'h0000_1C80_0000_0000, 64'h0000_1C80_0000_0000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000},
        {64'hFF80_7F80_0000_7F80, 64'h3F80_3F80_0000_0000, 64'h0000_0000_3F80_0000, 64'h7FC0_0000_7FC0_0000},
        {64'h0000_0000_0000_7180, 64'h0000_0000_0000_7180, 64'h7F81_2345_3F80_0000, 64'h7FC0_0000_7F80_0000},
        {64'h0000_BF80_8000_8000, 64'h0000_4040_3F80_3F80, 64'hC000_0000_8000_0000, 64'hC0A0_0000_8000_0000},
        {64'h0000_BF7F_0000_3FC0, 64'h0000_3F80_0000_3380, 64'h3F80_0000_3F80_0000, 64'h3B80_0000_3F80_0001}
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R1 lane layout";
            1: return "R2 product sum first";
            2: return "R3 tie to even";
            3: return "R4 flush to zero";
            4: return "R5 default NaN";
            5: return "R6 overflow to infinity";
            6: return "R12 signed zero";
            default: return "R3 sticky and renormalise";
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(logic wide, logic [4:0] d, logic [4:0] a, logic [4:0] b, int v);
        in_valid  = 1'b1;
        wide_mode = wide;
        dst_idx   = d;
        srca_idx  = a;
        srcb_idx  = b;
        srca_word = VEC[v][255:192];
        srcb_word = VEC[v][191:128];
        acc_word  = VEC[v][127:64];
    endtask

    task automatic expect_result(string req, int v);
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check({req, " illegal"}, 64'(out_illegal), 64'd0);
        check({req, " data"}, out_word, VEC[v][63:0]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 ready in reset", 64'(in_ready), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 ready after reset", 64'(in_ready), 64'd1);
        check("R11 valid after reset", 64'(out_valid), 64'd0);
        check("R11 illegal after reset", 64'(out_illegal), 64'd0);

        // Table walk, narrow mode, odd indices (R7: indices ignored)
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            drive(1'b0, 5'd1, 5'd3, 5'd5, i);
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            expect_result(vec_tag(i), i);
            @(negedge clk);
            check("R7 single-cycle valid", 64'(out_valid), 64'd0);
        end

        // R8/R10: legal wide pair, second beat with odd indices
        @(negedge clk); drive(1'b1, 5'd2, 5'd4, 5'd6, 0);
        @(negedge clk); drive(1'b1, 5'd3, 5'd5, 5'd7, 1);
        @(negedge clk); in_valid = 1'b0;
        expect_result("R8 wide beat 0", 0);
        @(negedge clk);
        expect_result("R10 wide beat 1 odd indices", 1);

        // R9: refused first beat, then another odd first beat is refused too
        @(negedge clk); drive(1'b1, 5'd2, 5'd4, 5'd1, 2);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R9 illegal pulse", 64'(out_illegal), 64'd1);
        check("R9 no valid", 64'(out_valid), 64'd0);
        @(negedge clk);
        check("R9 pulse one cycle", 64'(out_illegal), 64'd0);
        @(negedge clk); drive(1'b1, 5'd9, 5'd0, 5'd0, 3);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R9 phase stays first", 64'(out_illegal), 64'd1);
        check("R9 phase stays first valid", 64'(out_valid), 64'd0);

        // R8: a legal pair still works after refusals
        @(negedge clk); drive(1'b1, 5'd0, 5'd8, 5'd10, 4);
        @(negedge clk); drive(1'b1, 5'd1, 5'd9, 5'd11, 5);
        @(negedge clk); in_valid = 1'b0;
        expect_result("R8 pair after refusal beat 0", 4);
        @(negedge clk);
        expect_result("R8 pair after refusal beat 1", 5);

        // R7: back-to-back narrow beats
        @(negedge clk); drive(1'b0, 5'd0, 5'd0, 5'd0, 6);
        @(negedge clk); drive(1'b0, 5'd0, 5'd0, 5'd0, 7);
        @(negedge clk); in_valid = 1'b0;
        expect_result("R7 back-to-back first", 6);
        @(negedge clk);
        expect_result("R7 back-to-back second", 7);
        @(negedge clk);
        check("R7 idle after burst", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule